// File: doc/BRIEF.md
# Daisy-Chainable Serial Register Target

This block is a serial-peripheral target that exchanges fixed 29-bit frames with a host controller and turns every complete frame into one parallel register request. A request carries a command bit, a 12-bit address and 8-bit write data. A downstream engine answers each request with a response pulse that carries read data and a NACK indication. It also drives a level that says it is still working on something.

While a frame is being shifted in, the target shifts out the previous frame it received, MSB first. Before that frame goes out, the target writes its own status into it: a busy flag, a NACK flag and a reject flag. For reads, the data returned by the engine replaces the data byte. Because each target repeats what it was given one frame later, several targets can share a single select line, with each one's serial output feeding the next one's serial input. A frame that arrives while the target is still busy is not forwarded. It is only marked as rejected in the next echo.

The serial clock exists only during a frame, so the serial side and the system clock side exchange frames through a toggle request/acknowledge pair. The toggle is synchronized over two flops. The echo image is built in the system clock domain and held still while select is low.

Top module: `chain_spi_target`

## Requirements
- R1: A frame is carried while `spi_sel_n` is low, with data sampled on rising `spi_sck`. Bit 28 is sent first and is the command (1 = read, 0 = write). Bits 27:16 are the address and bits 7:0 are the data, with bit 0 sent last. When select rises after exactly 29 rising edges, a single one-cycle `req_valid` pulse is issued carrying those fields.
- R2: A frame with any other number of rising edges is discarded. It issues no request and leaves the next echo unchanged.
- R3: `spi_sdo_oe` is high exactly while `spi_sel_n` is low, with no clock edge needed. While select is high, `spi_sdi` and `spi_sck` have no effect.
- R4: During a frame, `spi_sdo` presents the echo MSB first. Bit 28 appears as soon as select falls, and each later bit appears after a falling `spi_sck` edge.
- R5: In the echo, bit 28 and bits 27:16 are the previous accepted or rejected frame's command and address. Bits 7:0 hold that frame's write data for a write, the response read data for an accepted read, and zero for a rejected read.
- R6: In the echo, bit 15 is busy: the engine busy level, or a response that is still pending when the frame starts. Bit 13 is the NACK flag of the last response, and bit 12 is the reject flag. Bits 14 and 11:8 are zero.
- R7: A complete frame that arrives while `eng_busy` is high or a response is pending issues no request and sets the reject flag. The next accepted frame clears the flag.
- R8: At most one request is outstanding. No new `req_valid` is issued and `req_addr` is held until `rsp_valid` arrives.
- R9: The echo image does not change while select is low.
- R10: Two targets chained on one select line each shift out the frame they received one frame (29 clocks) earlier, with their own status written into it.
- R11: After reset, the first echo is all zeros and no request has been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sel_n | input | 1 | Active-low frame select |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_sdi | input | 1 | Serial data in |
| spi_sdo | output | 1 | Serial data out (valid when the enable is high) |
| spi_sdo_oe | output | 1 | Output driver enable for the pad |
| eng_busy | input | 1 | Downstream engine is busy |
| req_valid | output | 1 | One-cycle request pulse |
| req_rd | output | 1 | Request is a read |
| req_addr | output | 12 | Request address |
| req_wdata | output | 8 | Request write data |
| rsp_valid | input | 1 | Response pulse from the engine |
| rsp_rdata | input | 8 | Response read data |
| rsp_nack | input | 1 | Response reports a NACK |

## Verification
The bound checker watches the system side on every cycle. It checks that requests are single pulses and that no second request is issued while one is pending. It also checks that a frame arriving while busy never produces a request, that the request address holds while waiting, and that the echo image stays frozen while select is low. Other behaviour shows only in the bench's scenarios: the bit order on the wire, discarding of frames that are too short or too long, writing the status and read data into the echo, and the one-frame delay through a chain of two targets. The bench checks these by shifting whole frames and comparing each target against a behavioural model of both devices and the engine.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
  localparam int FRAME_W = 29;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 8;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } spi_hdr_t;

  function automatic logic [FRAME_W-1:0] pack_echo(
    input logic              rd,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] data,
    input logic              busy,
    input logic              nack,
    input logic              rej
  );
    return {rd, addr, busy, 1'b0, nack, rej, 4'b0000, data};
  endfunction
endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_tgt_shifter.sv
module spi_tgt_shifter
  import spi_tgt_pkg::*;
(
  input  logic               rst,
  input  logic               sel_n,
  input  logic               sck,
  input  logic               sdi,
  input  logic [FRAME_W-1:0] tx_frame,
  input  logic               ack_tgl,
  output logic               sdo,
  output logic               sdo_oe,
  output logic               req_tgl,
  output spi_hdr_t           rx_hold
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic [CNT_W-1:0]   rise_cnt;
  logic [CNT_W-1:0]   out_idx;
  logic [FRAME_W-1:0] rx_shift;

  // rising-edge counter, saturates one above a full frame
  always_ff @(posedge sck or posedge sel_n) begin
    if (sel_n)                     rise_cnt <= '0;
    else if (rise_cnt != CNT_OVER) rise_cnt <= rise_cnt + 1'b1;
  end

  always_ff @(posedge sck) begin
    if (!sel_n) rx_shift <= {rx_shift[FRAME_W-2:0], sdi};
  end

  // output position advances on the falling edge
  always_ff @(negedge sck or posedge sel_n) begin
    if (sel_n) out_idx <= '0;
    else       out_idx <= rise_cnt;
  end

  always_comb begin
    sdo = 1'b0;
    if (out_idx < CNT_FULL) sdo = tx_frame[(FRAME_W-1) - int'(out_idx)];
  end

  assign sdo_oe = ~sel_n;

  // frame close: keep the header only after exactly FRAME_W edges
  always_ff @(posedge sel_n or posedge rst) begin
    if (rst) begin
      req_tgl <= 1'b0;
      rx_hold <= '0;
    end else if (rise_cnt == CNT_FULL && ack_tgl == req_tgl) begin
      rx_hold.rd   <= rx_shift[FRAME_W-1];
      rx_hold.addr <= rx_shift[FRAME_W-2 -: ADDR_W];
      rx_hold.data <= rx_shift[DATA_W-1:0];
      req_tgl      <= ~req_tgl;
    end
  end
endmodule

// File: rtl/spi_tgt_req_ctrl.sv
module spi_tgt_req_ctrl
  import spi_tgt_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               req_tgl_s,
  input  logic               sel_idle,
  input  spi_hdr_t           rx_hold,
  input  logic               eng_busy,
  input  logic               rsp_valid,
  input  logic [DATA_W-1:0]  rsp_rdata,
  input  logic               rsp_nack,
  output logic               req_valid,
  output logic               req_rd,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [DATA_W-1:0]  req_wdata,
  output logic               ack_tgl,
  output logic [FRAME_W-1:0] tx_frame,
  output logic               waiting,
  output logic               new_frame
);
  logic              seen;
  spi_hdr_t          hdr;
  logic [DATA_W-1:0] rdata_q;
  logic              nack_q;
  logic              rej_q;
  logic              live_q;
  logic [DATA_W-1:0] echo_data;

  assign new_frame = req_tgl_s ^ seen;
  assign echo_data = hdr.rd ? rdata_q : hdr.data;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen      <= 1'b0;
      ack_tgl   <= 1'b0;
      hdr       <= '0;
      rdata_q   <= '0;
      nack_q    <= 1'b0;
      rej_q     <= 1'b0;
      live_q    <= 1'b0;
      waiting   <= 1'b0;
      req_valid <= 1'b0;
      req_rd    <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
      tx_frame  <= '0;
    end else begin
      req_valid <= 1'b0;
      if (rsp_valid && waiting) begin
        waiting <= 1'b0;
        nack_q  <= rsp_nack;
        if (live_q && hdr.rd) rdata_q <= rsp_rdata;
      end
      if (new_frame) begin
        seen    <= req_tgl_s;
        ack_tgl <= req_tgl_s;
        hdr     <= rx_hold;
        rdata_q <= '0;
        if (waiting || eng_busy) begin
          rej_q  <= 1'b1;
          live_q <= 1'b0;
        end else begin
          rej_q     <= 1'b0;
          live_q    <= 1'b1;
          waiting   <= 1'b1;
          req_valid <= 1'b1;
          req_rd    <= rx_hold.rd;
          req_addr  <= rx_hold.addr;
          req_wdata <= rx_hold.data;
        end
      end
      if (sel_idle)
        tx_frame <= pack_echo(hdr.rd, hdr.addr, echo_data,
                              eng_busy | waiting, nack_q, rej_q);
    end
  end
endmodule

// File: rtl/chain_spi_target.sv
module chain_spi_target
  import spi_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sel_n,
  input  logic              spi_sck,
  input  logic              spi_sdi,
  output logic              spi_sdo,
  output logic              spi_sdo_oe,
  input  logic              eng_busy,
  output logic              req_valid,
  output logic              req_rd,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata,
  input  logic              rsp_nack
);
  logic               req_tgl;
  logic               req_tgl_s;
  logic               ack_tgl;
  logic               sel_idle;
  logic               waiting;
  logic               new_frame;
  logic [FRAME_W-1:0] tx_frame;
  spi_hdr_t           rx_hold;

  spi_tgt_shifter u_shift (
    .rst      (rst),
    .sel_n    (spi_sel_n),
    .sck      (spi_sck),
    .sdi      (spi_sdi),
    .tx_frame (tx_frame),
    .ack_tgl  (ack_tgl),
    .sdo      (spi_sdo),
    .sdo_oe   (spi_sdo_oe),
    .req_tgl  (req_tgl),
    .rx_hold  (rx_hold)
  );

  spi_tgt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_req (
    .clk (clk), .rst (rst), .d (req_tgl), .q (req_tgl_s)
  );

  spi_tgt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sel (
    .clk (clk), .rst (rst), .d (spi_sel_n), .q (sel_idle)
  );

  spi_tgt_req_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_tgl_s (req_tgl_s),
    .sel_idle  (sel_idle),
    .rx_hold   (rx_hold),
    .eng_busy  (eng_busy),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_nack  (rsp_nack),
    .req_valid (req_valid),
    .req_rd    (req_rd),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ack_tgl   (ack_tgl),
    .tx_frame  (tx_frame),
    .waiting   (waiting),
    .new_frame (new_frame)
  );
endmodule

// File: rtl/chain_spi_target_chk.sv
module chain_spi_target_chk
  import spi_tgt_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               rsp_valid,
  input logic               eng_busy,
  input logic               waiting,
  input logic               new_frame,
  input logic               sel_idle,
  input logic [FRAME_W-1:0] tx_frame
);
  a_r1_req_single_pulse: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid);

  a_r7_busy_no_request: assert property (@(posedge clk) disable iff (rst)
    (new_frame && (waiting || eng_busy)) |=> !req_valid);

  a_r8_one_outstanding: assert property (@(posedge clk) disable iff (rst)
    waiting |=> !req_valid);

  a_r8_addr_held: assert property (@(posedge clk) disable iff (rst)
    waiting |=> $stable(req_addr));

  a_r8_rsp_clears_wait: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && waiting) |=> !waiting);

  a_r9_echo_frozen: assert property (@(posedge clk) disable iff (rst)
    !sel_idle |=> $stable(tx_frame));
endmodule

bind chain_spi_target chain_spi_target_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .eng_busy  (eng_busy),
  .waiting   (waiting),
  .new_frame (new_frame),
  .sel_idle  (sel_idle),
  .tx_frame  (tx_frame)
);

// File: tb/tb_chain_spi_target.sv
module tb_chain_spi_target;
  import spi_tgt_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int SCK_HALF   = 40;
  localparam int GAP_CLKS   = 40;
  localparam int RSP_LAT    = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b1;
  logic sck = 1'b0;
  logic host_sdi = 1'b0;

  logic a_sdo, a_oe, a_req_valid, a_req_rd;
  logic [11:0] a_req_addr;
  logic [7:0]  a_req_wdata;
  logic a_rsp_valid = 1'b0, a_rsp_nack = 1'b0, a_busy = 1'b0;
  logic [7:0] a_rsp_rdata = 8'h00;

  logic b_sdi, b_sdo, b_oe, b_req_valid, b_req_rd;
  logic [11:0] b_req_addr;
  logic [7:0]  b_req_wdata;
  logic b_rsp_valid = 1'b0;
  logic [7:0] b_rsp_rdata = 8'h00;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign b_sdi = a_oe ? a_sdo : 1'b0;

  chain_spi_target dut (
    .clk(clk), .rst(rst), .spi_sel_n(sel_n), .spi_sck(sck), .spi_sdi(host_sdi),
    .spi_sdo(a_sdo), .spi_sdo_oe(a_oe), .eng_busy(a_busy),
    .req_valid(a_req_valid), .req_rd(a_req_rd), .req_addr(a_req_addr),
    .req_wdata(a_req_wdata), .rsp_valid(a_rsp_valid), .rsp_rdata(a_rsp_rdata),
    .rsp_nack(a_rsp_nack)
  );

  chain_spi_target dut_b (
    .clk(clk), .rst(rst), .spi_sel_n(sel_n), .spi_sck(sck), .spi_sdi(b_sdi),
    .spi_sdo(b_sdo), .spi_sdo_oe(b_oe), .eng_busy(1'b0),
    .req_valid(b_req_valid), .req_rd(b_req_rd), .req_addr(b_req_addr),
    .req_wdata(b_req_wdata), .rsp_valid(b_rsp_valid), .rsp_rdata(b_rsp_rdata),
    .rsp_nack(1'b0)
  );

  // engine stubs: record requests, answer after a fixed latency
  logic [7:0]  stub_mem [0:4095];
  logic [20:0] q_a[$];
  logic [20:0] q_b[$];
  int lat_a = 0, lat_b = 0;
  logic [20:0] pend_a, pend_b;

  always @(negedge clk) begin
    a_rsp_valid <= 1'b0;
    if (rst) lat_a = 0;
    else if (a_req_valid) begin
      pend_a = {a_req_rd, a_req_addr, a_req_wdata};
      q_a.push_back(pend_a);
      lat_a = RSP_LAT;
    end else if (lat_a > 0) begin
      lat_a--;
      if (lat_a == 0) begin
        a_rsp_valid <= 1'b1;
        a_rsp_nack  <= (pend_a[19:16] == 4'hF);
        a_rsp_rdata <= (pend_a[19:16] == 4'hF) ? 8'hEE : stub_mem[pend_a[19:8]];
        if (!pend_a[20] && pend_a[19:16] != 4'hF) stub_mem[pend_a[19:8]] = pend_a[7:0];
      end
    end
  end

  always @(negedge clk) begin
    b_rsp_valid <= 1'b0;
    if (rst) lat_b = 0;
    else if (b_req_valid) begin
      pend_b = {b_req_rd, b_req_addr, b_req_wdata};
      q_b.push_back(pend_b);
      lat_b = RSP_LAT;
    end else if (lat_b > 0) begin
      lat_b--;
      if (lat_b == 0) begin
        b_rsp_valid <= 1'b1;
        b_rsp_rdata <= {pend_b[11:8], pend_b[15:12]};
      end
    end
  end

  // behavioural model of both targets
  logic [7:0]  m_mem [0:4095];
  logic        m_rd[2], m_nack[2], m_rej[2];
  logic [11:0] m_addr[2];
  logic [7:0]  m_dat[2];

  function automatic logic [28:0] model_echo(int dev, logic busy);
    return {m_rd[dev], m_addr[dev], busy, 1'b0, m_nack[dev], m_rej[dev], 4'b0000, m_dat[dev]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_update(input int dev, input logic [28:0] fin, input logic busy_now,
                              output logic accepted);
    logic nk;
    logic [7:0] rdv;
    m_rd[dev]   = fin[28];
    m_addr[dev] = fin[27:16];
    if (busy_now) begin
      m_rej[dev] = 1'b1;
      m_dat[dev] = fin[28] ? 8'h00 : fin[7:0];
      accepted = 1'b0;
    end else begin
      m_rej[dev] = 1'b0;
      accepted = 1'b1;
      if (dev == 0) begin
        nk  = (fin[27:24] == 4'hF);
        rdv = nk ? 8'hEE : m_mem[fin[27:16]];
        if (!fin[28] && !nk) m_mem[fin[27:16]] = fin[7:0];
      end else begin
        nk  = 1'b0;
        rdv = {fin[19:16], fin[23:20]};
      end
      m_nack[dev] = nk;
      m_dat[dev]  = fin[28] ? rdv : fin[7:0];
    end
  endtask

  task automatic check_reqs(input string tag, input int dev, input logic acc, input logic [28:0] fin);
    int n;
    logic [20:0] got;
    n = (dev == 0) ? q_a.size() : q_b.size();
    check({tag, " request count"}, n, acc ? 1 : 0);
    if (n > 0) begin
      got = (dev == 0) ? q_a.pop_front() : q_b.pop_front();
      if (acc) check({tag, " request fields"}, got, {fin[28], fin[27:16], fin[7:0]});
    end
    if (dev == 0) q_a.delete(); else q_b.delete();
  endtask

  function automatic logic [28:0] mk(logic rd, logic [11:0] addr, logic [7:0] data);
    return {rd, addr, 8'hC3, data};
  endfunction

  task automatic frame(input string tag, input logic [28:0] f, input int nbits);
    logic [28:0] exp_a, exp_b, cap_a, cap_b, mask;
    logic acc_a, acc_b;
    exp_a = model_echo(0, a_busy);
    exp_b = model_echo(1, 1'b0);
    cap_a = '0; cap_b = '0; mask = '0;
    sel_n = 1'b0;
    #(SCK_HALF/2);
    check("R3 oe on select low", {a_oe, b_oe}, 2'b11);
    #(SCK_HALF/2);
    for (int i = 0; i < nbits; i++) begin
      host_sdi = (i < 29) ? f[28-i] : 1'b0;
      #(SCK_HALF);
      if (i < 29) begin
        cap_a[28-i] = a_sdo;
        cap_b[28-i] = b_sdo;
        mask[28-i]  = 1'b1;
      end
      sck = 1'b1;
      #(SCK_HALF);
      sck = 1'b0;
    end
    #(SCK_HALF);
    sel_n = 1'b1;
    repeat (GAP_CLKS) @(posedge clk);
    #1;
    check("R3 oe off select high", {a_oe, b_oe}, 2'b00);
    check({tag, " R4/R5/R6 echo A"}, cap_a & mask, exp_a & mask);
    check({tag, " R10 echo B"}, cap_b & mask, exp_b & mask);
    if (nbits == 29) begin
      model_update(0, f, a_busy, acc_a);
      model_update(1, exp_a, 1'b0, acc_b);
      check_reqs({tag, " R1/R7 A"}, 0, acc_a, f);
      check_reqs({tag, " R10 B"}, 1, acc_b, exp_a);
    end else begin
      check_reqs({tag, " R2 A"}, 0, 1'b0, f);
      check_reqs({tag, " R2 B"}, 1, 1'b0, f);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    vectors++;
    $display("FAIL watchdog actual=expired expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4096; i++) begin
      stub_mem[i] = 8'h00;
      m_mem[i]    = 8'h00;
    end
    for (int d = 0; d < 2; d++) begin
      m_rd[d] = 0; m_nack[d] = 0; m_rej[d] = 0; m_addr[d] = 0; m_dat[d] = 0;
    end
    repeat (5) @(posedge clk);
    rst = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    check("R11 no request after reset", {a_req_valid, b_req_valid}, 2'b00);
    check("R3 oe idle after reset", {a_oe, b_oe}, 2'b00);

    frame("R11 first frame", mk(1'b0, 12'h012, 8'hA5), 29);
    frame("read back", mk(1'b1, 12'h012, 8'h00), 29);
    frame("nack write", mk(1'b0, 12'hF05, 8'h3C), 29);
    frame("plain read", mk(1'b1, 12'h034, 8'h99), 29);
    frame("short frame", mk(1'b0, 12'h777, 8'h11), 28);
    frame("long frame", mk(1'b0, 12'h778, 8'h12), 30);

    // R3: clock and data toggling while select is high
    for (int i = 0; i < 10; i++) begin
      host_sdi = i[0];
      #(SCK_HALF); sck = 1'b1;
      check("R3 oe stays off", a_oe, 1'b0);
      #(SCK_HALF); sck = 1'b0;
    end
    repeat (GAP_CLKS) @(posedge clk);
    check_reqs("R3 idle toggles A", 0, 1'b0, '0);

    frame("R2/R3 echo unchanged", mk(1'b0, 12'h100, 8'h77), 29);
    a_busy = 1'b1;
    repeat (4) @(posedge clk);
    frame("R7 busy write", mk(1'b0, 12'h200, 8'h11), 29);
    frame("R7 busy read", mk(1'b1, 12'h100, 8'h00), 29);
    a_busy = 1'b0;
    repeat (4) @(posedge clk);
    frame("R7 reject shown", mk(1'b0, 12'h101, 8'h22), 29);
    frame("R7 reject cleared", mk(1'b1, 12'h101, 8'h00), 29);
    frame("read data echo", mk(1'b1, 12'h000, 8'h5A), 29);
    frame("flush", mk(1'b0, 12'hABC, 8'hFF), 29);
    frame("flush chain", mk(1'b1, 12'h012, 8'h00), 29);
    finish_run();
  end
endmodule